// File: doc/BRIEF.md
# Double-Width Funnel Right Shifter

This unit joins two operands into one double-width value and shifts that value right by a variable amount. The high operand supplies the upper half and the low operand the lower half. The low half of the shifted value is the result. Bits of the high operand therefore fall into the result from the top, while the high operand itself is left untouched. Chained across a pair of registers, this gives a wide logical right shift.

A size input selects between two modes. In 16-bit mode the operands are 16 bits each and the joined value is 32 bits. In 32-bit mode the operands are 32 bits each and the joined value is 64 bits. The shift amount comes from an 8-bit count input, and only its low five bits are used.

The unit registers its result, its status flags and a flag-write strobe one cycle after a valid request. The status flags are carry, sign, zero and parity. Overflow and auxiliary carry are tied to zero.

Top module: `fsh_right_top`

## Requirements
- R1: In 32-bit mode (`size32`=1), `result` equals bits 31:0 of the 64-bit value {`op_hi`,`op_lo`} shifted right logically by the masked count.
- R2: In 16-bit mode (`size32`=0), the joined value is {`op_hi[15:0]`,`op_lo[15:0]`}, `result[15:0]` is its low 16 bits after the shift, and `result[31:16]` is 0. With a count of 16..31, bits of `op_hi` reach `result`.
- R3: Only `cnt_in[4:0]` sets the shift amount, so bits 7:5 of the count have no effect on any output.
- R4: For a masked count c from 1 to 31, `cf` equals bit c-1 of the joined value.
- R5: When flags are written, `sf` is the top bit of the result at the active width (bit 31 or bit 15). `zf` is 1 exactly when the result is zero. `pf` is 1 when `result[7:0]` holds an even number of 1 bits.
- R6: A masked count of 0 gives `result` equal to `op_lo` at the active width and drives `flags_we` to 0. In that case `cf`, `sf`, `zf` and `pf` keep their previous values.
- R7: `of` and `af` are always 0.
- R8: All outputs update one clock after a request with `in_valid`=1, and `out_valid` follows `in_valid` with one cycle of delay. With `in_valid`=0, `result` and the flags hold and `flags_we` is 0.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| size32 | input | 1 | 1: 32-bit operands, 0: 16-bit operands |
| op_lo | input | 32 | Low operand; the result replaces it |
| op_hi | input | 32 | High operand, never modified |
| cnt_in | input | 8 | Shift count, low 5 bits used |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Shifted low half |
| cf | output | 1 | Carry: last bit shifted out |
| sf | output | 1 | Sign of the result |
| zf | output | 1 | Result is zero |
| pf | output | 1 | Even parity of the result's low byte |
| of | output | 1 | Overflow, tied to 0 |
| af | output | 1 | Auxiliary carry, tied to 0 |
| flags_we | output | 1 | Flags were written by this result |

## Verification
The assertions assume that `size32` and `cnt_in` are known, non-X values whenever `in_valid` is high. They also assume that a request is judged only against the inputs seen at the edge that captures it. The stimulus changes inputs only on falling edges and always drives defined values. It sweeps every one of the 256 count values in both sizes with random operands. It also interleaves idle cycles and zero-count requests, so that the hold paths are checked with flags that were set earlier.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int unsigned OP_W  = 32;
    localparam int unsigned CNT_W = 8;

    typedef struct packed {
        logic            vld;
        logic            we;
        logic [OP_W-1:0] res;
        logic            cf;
        logic            sf;
        logic            zf;
        logic            pf;
    } fsh_state_t;
endpackage

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
    parameter int unsigned W = 32
) (
    input  logic                 size32,
    input  logic [W-1:0]         hi,
    input  logic [W-1:0]         lo,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         res,
    output logic                 cout
);
    localparam int unsigned HALF = W / 2;
    localparam int unsigned EW   = 2 * W + 1;

    logic [EW-1:0] ext;
    logic [EW-1:0] sh;
    logic [W-1:0]  raw;

    // A guard bit below the joined value catches the last bit shifted out.
    always_comb begin
        if (size32) ext = {hi, lo, 1'b0};
        else        ext = {{W{1'b0}}, hi[HALF-1:0], lo[HALF-1:0], 1'b0};
        sh   = ext >> amt;
        raw  = sh[W:1];
        cout = sh[0];
        res  = size32 ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end
endmodule

// File: rtl/fsh_flags.sv
module fsh_flags #(
    parameter int unsigned W = 32
) (
    input  logic         size32,
    input  logic [W-1:0] res,
    output logic         sf,
    output logic         zf,
    output logic         pf
);
    localparam int unsigned HALF = W / 2;

    always_comb begin
        sf = size32 ? res[W-1] : res[HALF-1];
        zf = (res == '0);
        pf = ~^res[7:0];
    end
endmodule

// File: rtl/fsh_right_top.sv
module fsh_right_top
    import fsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             size32,
    input  logic [OP_W-1:0]  op_lo,
    input  logic [OP_W-1:0]  op_hi,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             out_valid,
    output logic [OP_W-1:0]  result,
    output logic             cf,
    output logic             sf,
    output logic             zf,
    output logic             pf,
    output logic             of,
    output logic             af,
    output logic             flags_we
);
    localparam int unsigned AMT_W = $clog2(OP_W);

    fsh_state_t       st_d, st_q;
    logic [AMT_W-1:0] amt;
    logic [OP_W-1:0]  sh_res;
    logic             sh_cf, n_sf, n_zf, n_pf;

    assign amt = cnt_in[AMT_W-1:0];

    fsh_funnel #(.W(OP_W)) u_funnel (
        .size32 (size32),
        .hi     (op_hi),
        .lo     (op_lo),
        .amt    (amt),
        .res    (sh_res),
        .cout   (sh_cf)
    );

    fsh_flags #(.W(OP_W)) u_flags (
        .size32 (size32),
        .res    (sh_res),
        .sf     (n_sf),
        .zf     (n_zf),
        .pf     (n_pf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = 1'b0;
        if (in_valid) begin
            st_d.res = sh_res;
            if (amt != '0) begin
                st_d.we = 1'b1;
                st_d.cf = sh_cf;
                st_d.sf = n_sf;
                st_d.zf = n_zf;
                st_d.pf = n_pf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cf        = st_q.cf;
    assign sf        = st_q.sf;
    assign zf        = st_q.zf;
    assign pf        = st_q.pf;
    assign flags_we  = st_q.we;
    assign of        = 1'b0;
    assign af        = 1'b0;
endmodule

// File: rtl/fsh_chk.sv
module fsh_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        size32,
    input logic [31:0] op_lo,
    input logic [7:0]  cnt_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        cf,
    input logic        sf,
    input logic        zf,
    input logic        pf,
    input logic        of,
    input logic        af,
    input logic        flags_we
);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (of == 1'b0) && (af == 1'b0));

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !flags_we && $stable(result)));

    a_r6_zero_cnt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_in[4:0] == 5'd0) |=> !flags_we);

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |-> $stable({cf, sf, zf, pf}));

    a_r6_zero_cnt_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size32 && cnt_in[4:0] == 5'd0) |=> (result == $past(op_lo)));

    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size32) |=> (result[31:16] == 16'h0));

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (zf == (result == 32'h0)));
endmodule

bind fsh_right_top fsh_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size32    (size32),
    .op_lo     (op_lo),
    .cnt_in    (cnt_in),
    .out_valid (out_valid),
    .result    (result),
    .cf        (cf),
    .sf        (sf),
    .zf        (zf),
    .pf        (pf),
    .of        (of),
    .af        (af),
    .flags_we  (flags_we)
);

// File: tb/sim_fsh_right_top.sv
module sim_fsh_right_top;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        size32 = 1'b0;
    logic [31:0] op_lo = '0;
    logic [31:0] op_hi = '0;
    logic [7:0]  cnt_in = '0;
    logic        out_valid, cf, sf, zf, pf, of, af, flags_we;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // expected flag state kept by the bench
    logic e_cf = 0, e_sf = 0, e_zf = 0, e_pf = 0;

    always #(CLK_P/2) clk = ~clk;

    fsh_right_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size32(size32),
        .op_lo(op_lo), .op_hi(op_hi), .cnt_in(cnt_in),
        .out_valid(out_valid), .result(result), .cf(cf), .sf(sf), .zf(zf),
        .pf(pf), .of(of), .af(af), .flags_we(flags_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] joined(input logic sz, input logic [31:0] hi, input logic [31:0] lo);
        return sz ? {hi, lo} : {32'h0, hi[15:0], lo[15:0]};
    endfunction

    function automatic logic [31:0] ref_res(input logic sz, input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] c);
        logic [63:0] r;
        r = joined(sz, hi, lo) >> c[4:0];
        return sz ? r[31:0] : {16'h0, r[15:0]};
    endfunction

    // drive one request, then check at the next falling edge
    task automatic run(input logic sz, input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] c);
        logic [31:0] er;
        logic [63:0] j;
        int          k;
        k  = int'(c[4:0]);
        j  = joined(sz, hi, lo);
        er = ref_res(sz, hi, lo, c);
        size32 = sz; op_hi = hi; op_lo = lo; cnt_in = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (k != 0) begin
            e_cf = j[k-1];
            e_sf = sz ? er[31] : er[15];
            e_zf = (er == 32'h0);
            e_pf = ~^er[7:0];
        end
        chk(result === er, sz ? "R1 R3 result" : "R2 R3 result", result, er);
        chk(cf === e_cf, "R4 carry", {31'h0, cf}, {31'h0, e_cf});
        chk({sf, zf, pf} === {e_sf, e_zf, e_pf}, "R5 sign/zero/parity",
            {29'h0, sf, zf, pf}, {29'h0, e_sf, e_zf, e_pf});
        chk(flags_we === (k != 0), "R6 flags_we", {31'h0, flags_we}, {31'h0, k != 0});
        chk({of, af} === 2'b00, "R7 of/af", {30'h0, of, af}, 32'h0);
        chk(out_valid === 1'b1, "R8 out_valid", {31'h0, out_valid}, 32'h1);
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5eed1234));
        @(negedge clk);
        @(negedge clk);
        chk({out_valid, cf, sf, zf, pf, of, af, flags_we} === 8'h0 && result === 32'h0,
            "R9 reset outputs", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed vector
        run(1'b1, 32'hFEDCBA98, 32'h76543210, 8'd8);
        chk(result === 32'h98765432, "R1 directed", result, 32'h98765432);
        // upper count bits ignored
        run(1'b1, 32'hFEDCBA98, 32'h76543210, 8'hE8);
        chk(result === 32'h98765432, "R3 masked count", result, 32'h98765432);
        // 16-bit with count 20: high bits enter
        run(1'b0, 32'h0000ABCD, 32'h00001234, 8'd20);
        chk(result === 32'h00000ABC, "R2 hi bits enter", result, 32'h00000ABC);
        // zero result, carry from top
        run(1'b1, 32'h80000000, 32'h0, 8'd31);
        run(1'b1, 32'h0, 32'h80000000, 8'd31);
        chk(zf === 1'b0 && result === 32'h1, "R5 nonzero", result, 32'h1);
        run(1'b1, 32'h0, 32'h40000000, 8'd31);
        chk(zf === 1'b1 && cf === 1'b1, "R4 R5 zero with carry", {30'h0, zf, cf}, 32'h3);
        // zero count: flags keep previous value
        run(1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h20);
        chk(zf === 1'b1 && result === 32'h0, "R6 hold after zero count", result, 32'h0);

        // idle cycle holds outputs
        held = result;
        @(negedge clk);
        chk(out_valid === 1'b0 && flags_we === 1'b0 && result === held,
            "R8 idle hold", result, held);

        for (int sz = 0; sz < 2; sz++) begin
            for (int c = 0; c < 256; c++) begin
                run(sz[0], $urandom(), $urandom(), c[7:0]);
                if (c % 37 == 0) @(negedge clk);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule